// File: doc/BRIEF.md
# Page Table Entry Classifier

This block inspects a single page table entry during one step of a hardware page walk and decides what the walker does next. It sorts the entry into exactly one of three outcomes: a fault, a leaf that maps a page, or a pointer to the next table level. For a fault it reports a code naming the first rule the entry broke. The walker supplies the entry word, the number of page-number bits that must be zero at this level for a superpage, and two enables. One enable allows the memory-type field and the other allows the contiguous-page bit.

The page number is always turned into a physical base address by shifting it left by the page offset width. A pointer uses that address for its next table, and a leaf uses it as its page frame. Fetching the entry, checking permissions against the access and updating accessed or dirty bits are left to the surrounding walker. With the default setting the result is registered, so it appears one clock after the entry is presented.

Top module: `pte_validity_chk`

## Requirements
- R1: While rst_n is low, fault_o, leaf_o and next_o are 0 and reason_o is 0. With the default registered output, each result appears on the clock edge after its inputs are presented.
- R2: The entry is invalid when the valid bit (bit 0) is clear, or when write (bit 2) is set while read (bit 1) is clear. An invalid entry reports reason 1 whatever else is set.
- R3: Any nonzero reserved bit in bits 60:54 is a fault with reason 2.
- R4: A nonzero memory-type field (bits 62:61) while mt_en_i is 0 is a fault with reason 3. This holds for leaf entries and for pointer entries. While mt_en_i is 1, the field does not cause this fault.
- R5: A set contiguous bit (bit 63) while cont_en_i is 0 is a fault with reason 4. While cont_en_i is 1, a leaf with the bit set is accepted.
- R6: An entry that passes all checks is a leaf when any of read, write or execute (bits 3:1) is set, and a pointer otherwise. Once a result has been captured, exactly one of fault_o, leaf_o and next_o is 1.
- R7: A pointer entry is a fault with reason 5 when any of these is true: dirty (bit 7), accessed (bit 6) or user (bit 4) is set, the memory-type field is nonzero, or the contiguous bit is set.
- R8: A leaf whose page number (bits 53:10) has a 1 in any of its lowest lvl_shift_i positions is a fault with reason 6. Pointer entries are not checked for alignment.
- R9: next_base_o equals the page number shifted left by 12 bits, for every entry.
- R10: The reason codes are 0 none, 1 invalid, 2 reserved, 3 memory type, 4 contiguous, 5 pointer attributes and 6 misaligned. When several checks fail, the lowest code is reported. fault_o is 1 exactly when reason_o is nonzero.
- R11: The global bit (bit 5) and the software bits (bits 9:8) have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the result register |
| pte_i | input | PTE_W | Entry word under test |
| mt_en_i | input | 1 | Memory-type field allowed |
| cont_en_i | input | 1 | Contiguous-page bit allowed |
| lvl_shift_i | input | SHIFT_W | Number of low page-number bits that must be zero for a leaf at this level |
| fault_o | output | 1 | Entry is faulty |
| leaf_o | output | 1 | Entry is a valid leaf |
| next_o | output | 1 | Entry is a valid pointer to the next level |
| reason_o | output | 3 | Fault reason code, 0 when there is no fault |
| next_base_o | output | PA_W | Page number shifted left by the page offset width |

## Verification
The bench targets the priority between overlapping faults. Examples are an invalid entry that also has reserved bits set, and a reserved-bit entry that also carries a disallowed memory type. A design with the order wrong would report the higher code instead of the lower one.

The bench also probes the alignment boundary. A page number with bit 9 set passes at shift 9 but fails at shift 10. An off-by-one mask would accept the second case or reject the first.

Pointer entries that carry memory-type or contiguous bits with the extensions enabled must still fault as pointer attributes, which catches a design that skips that check. Entries with the global and software bits set must classify unchanged, which catches a design that decodes bits it should ignore.

// File: rtl/pte_chk_pkg.sv
package pte_chk_pkg;

   localparam int REASON_W  = 3;
   localparam int NUM_RULES = 6;

   typedef enum logic [REASON_W-1:0] {
      PTE_OK          = 3'd0,
      PTE_BAD_INVALID = 3'd1,
      PTE_BAD_RSV     = 3'd2,
      PTE_BAD_MTYPE   = 3'd3,
      PTE_BAD_CONT    = 3'd4,
      PTE_BAD_PTRATTR = 3'd5,
      PTE_BAD_ALIGN   = 3'd6
   } pte_reason_e;

   typedef struct packed {
      logic v;
      logic r;
      logic w;
      logic x;
      logic u;
      logic g;
      logic a;
      logic d;
   } pte_flags_t;

   localparam int FLG_V = 0;
   localparam int FLG_R = 1;
   localparam int FLG_W = 2;
   localparam int FLG_X = 3;
   localparam int FLG_U = 4;
   localparam int FLG_G = 5;
   localparam int FLG_A = 6;
   localparam int FLG_D = 7;
   localparam int SW_LSB = 8;
   localparam int SW_W   = 2;

endpackage

// File: rtl/pte_field_split.sv
module pte_field_split
   import pte_chk_pkg::*;
#(
   parameter int PTE_W    = 64,
   parameter int PPN_LSB  = 10,
   parameter int PPN_W    = 44,
   parameter int RSV_LSB  = 54,
   parameter int RSV_W    = 7,
   parameter int MT_LSB   = 61,
   parameter int MT_W     = 2,
   parameter int CONT_POS = 63
) (
   input  logic [PTE_W-1:0] pte_i,
   output pte_flags_t       flags_o,
   output logic [PPN_W-1:0] ppn_o,
   output logic [RSV_W-1:0] rsv_o,
   output logic [MT_W-1:0]  mt_o,
   output logic             cont_o
);

   logic unused_sw;

   always_comb begin
      flags_o.v = pte_i[FLG_V];
      flags_o.r = pte_i[FLG_R];
      flags_o.w = pte_i[FLG_W];
      flags_o.x = pte_i[FLG_X];
      flags_o.u = pte_i[FLG_U];
      flags_o.g = pte_i[FLG_G];
      flags_o.a = pte_i[FLG_A];
      flags_o.d = pte_i[FLG_D];
   end

   assign ppn_o     = pte_i[PPN_LSB +: PPN_W];
   assign rsv_o     = pte_i[RSV_LSB +: RSV_W];
   assign mt_o      = pte_i[MT_LSB +: MT_W];
   assign cont_o    = pte_i[CONT_POS];
   // software bits carry no meaning for the classification
   assign unused_sw = ^pte_i[SW_LSB +: SW_W];

endmodule

// File: rtl/pte_rule_eval.sv
module pte_rule_eval
   import pte_chk_pkg::*;
#(
   parameter int PPN_W   = 44,
   parameter int RSV_W   = 7,
   parameter int MT_W    = 2,
   parameter int SHIFT_W = $clog2(PPN_W + 1)
) (
   input  pte_flags_t           flags_i,
   input  logic [PPN_W-1:0]     ppn_i,
   input  logic [RSV_W-1:0]     rsv_i,
   input  logic [MT_W-1:0]      mt_i,
   input  logic                 cont_i,
   input  logic                 mt_en_i,
   input  logic                 cont_en_i,
   input  logic [SHIFT_W-1:0]   lvl_shift_i,
   output logic [NUM_RULES:1]   hit_o,
   output logic                 is_leaf_o
);

   localparam int CMP_W = SHIFT_W + 1;

   logic [PPN_W-1:0] low_mask;
   logic             mt_nz;
   logic             ptr_attr;
   logic             unused_glob;

   // one mask bit per page-number position: set when below the level shift
   for (genvar i = 0; i < PPN_W; i++) begin : g_mask
      assign low_mask[i] = ({1'b0, lvl_shift_i} > CMP_W'(i));
   end

   assign mt_nz       = |mt_i;
   assign is_leaf_o   = flags_i.r | flags_i.w | flags_i.x;
   assign ptr_attr    = flags_i.d | flags_i.a | flags_i.u | mt_nz | cont_i;
   assign unused_glob = flags_i.g;

   always_comb begin
      hit_o    = '0;
      hit_o[1] = ~flags_i.v | (flags_i.w & ~flags_i.r);
      hit_o[2] = |rsv_i;
      hit_o[3] = mt_nz & ~mt_en_i;
      hit_o[4] = cont_i & ~cont_en_i;
      hit_o[5] = ~is_leaf_o & ptr_attr;
      hit_o[6] = is_leaf_o & (|(ppn_i & low_mask));
   end

endmodule

// File: rtl/pte_fault_prio.sv
module pte_fault_prio #(
   parameter int N    = 6,
   parameter int CODE_W = $clog2(N + 1)
) (
   input  logic [N:1]        hit_i,
   output logic [CODE_W-1:0] code_o,
   output logic              any_o
);

   // lowest-numbered rule wins: scan from the top so it is assigned last
   always_comb begin
      code_o = '0;
      for (int k = N; k >= 1; k--) begin
         if (hit_i[k]) begin
            code_o = CODE_W'(k);
         end
      end
   end

   assign any_o = |hit_i;

endmodule

// File: rtl/pte_validity_chk.sv
module pte_validity_chk
   import pte_chk_pkg::*;
#(
   parameter int PTE_W      = 64,
   parameter int PPN_LSB    = 10,
   parameter int PPN_W      = 44,
   parameter int RSV_LSB    = 54,
   parameter int RSV_W      = 7,
   parameter int MT_LSB     = 61,
   parameter int MT_W       = 2,
   parameter int CONT_POS   = 63,
   parameter int PAGE_SHIFT = 12,
   parameter bit REG_OUT    = 1'b1,
   localparam int SHIFT_W   = $clog2(PPN_W + 1),
   localparam int PA_W      = PPN_W + PAGE_SHIFT
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PTE_W-1:0]    pte_i,
   input  logic                mt_en_i,
   input  logic                cont_en_i,
   input  logic [SHIFT_W-1:0]  lvl_shift_i,
   output logic                fault_o,
   output logic                leaf_o,
   output logic                next_o,
   output logic [REASON_W-1:0] reason_o,
   output logic [PA_W-1:0]     next_base_o
);

   initial begin
      assert (PPN_LSB + PPN_W <= PTE_W) else $error("page number field exceeds entry");
      assert (RSV_LSB + RSV_W <= PTE_W) else $error("reserved field exceeds entry");
      assert (MT_LSB + MT_W <= PTE_W) else $error("memory-type field exceeds entry");
      assert (CONT_POS < PTE_W) else $error("contiguous bit outside entry");
      assert (PPN_LSB >= SW_LSB + SW_W) else $error("page number overlaps flag bits");
      assert (MT_W >= 1 && RSV_W >= 1) else $error("field widths must be nonzero");
      assert ($clog2(NUM_RULES + 1) == REASON_W) else $error("reason width mismatch");
   end

   pte_flags_t        flags;
   logic [PPN_W-1:0]  ppn;
   logic [RSV_W-1:0]  rsv;
   logic [MT_W-1:0]   mt;
   logic              cont;
   logic [NUM_RULES:1] hit;
   logic              is_leaf;
   logic [REASON_W-1:0] code;
   logic              any_fault;

   logic              c_fault;
   logic              c_leaf;
   logic              c_next;
   logic [PA_W-1:0]   c_base;

   pte_field_split #(
      .PTE_W    (PTE_W),
      .PPN_LSB  (PPN_LSB),
      .PPN_W    (PPN_W),
      .RSV_LSB  (RSV_LSB),
      .RSV_W    (RSV_W),
      .MT_LSB   (MT_LSB),
      .MT_W     (MT_W),
      .CONT_POS (CONT_POS)
   ) u_split (
      .pte_i   (pte_i),
      .flags_o (flags),
      .ppn_o   (ppn),
      .rsv_o   (rsv),
      .mt_o    (mt),
      .cont_o  (cont)
   );

   pte_rule_eval #(
      .PPN_W   (PPN_W),
      .RSV_W   (RSV_W),
      .MT_W    (MT_W),
      .SHIFT_W (SHIFT_W)
   ) u_rules (
      .flags_i     (flags),
      .ppn_i       (ppn),
      .rsv_i       (rsv),
      .mt_i        (mt),
      .cont_i      (cont),
      .mt_en_i     (mt_en_i),
      .cont_en_i   (cont_en_i),
      .lvl_shift_i (lvl_shift_i),
      .hit_o       (hit),
      .is_leaf_o   (is_leaf)
   );

   pte_fault_prio #(
      .N      (NUM_RULES),
      .CODE_W (REASON_W)
   ) u_prio (
      .hit_i  (hit),
      .code_o (code),
      .any_o  (any_fault)
   );

   assign c_fault = any_fault;
   assign c_leaf  = ~any_fault & is_leaf;
   assign c_next  = ~any_fault & ~is_leaf;
   assign c_base  = {ppn, {PAGE_SHIFT{1'b0}}};

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            fault_o     <= 1'b0;
            leaf_o      <= 1'b0;
            next_o      <= 1'b0;
            reason_o    <= PTE_OK;
            next_base_o <= '0;
         end else begin
            fault_o     <= c_fault;
            leaf_o      <= c_leaf;
            next_o      <= c_next;
            reason_o    <= code;
            next_base_o <= c_base;
         end
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk  = clk;
      assign fault_o     = rst_n & c_fault;
      assign leaf_o      = rst_n & c_leaf;
      assign next_o      = rst_n & c_next;
      assign reason_o    = rst_n ? code : PTE_OK;
      assign next_base_o = rst_n ? c_base : '0;
   end

endmodule

// File: rtl/pte_validity_chk_sva.sv
module pte_validity_chk_sva #(
   parameter int PTE_W      = 64,
   parameter int PPN_LSB    = 10,
   parameter int PPN_W      = 44,
   parameter int RSV_LSB    = 54,
   parameter int RSV_W      = 7,
   parameter int PAGE_SHIFT = 12,
   parameter bit REG_OUT    = 1'b1,
   parameter int SHIFT_W    = $clog2(PPN_W + 1),
   parameter int PA_W       = PPN_W + PAGE_SHIFT
) (
   input logic               clk,
   input logic               rst_n,
   input logic [PTE_W-1:0]   pte_i,
   input logic               fault_o,
   input logic               leaf_o,
   input logic               next_o,
   input logic [2:0]         reason_o,
   input logic [PA_W-1:0]    next_base_o
);

   logic [PTE_W-1:0] d_pte;
   logic             d_vld;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            d_pte <= '0;
            d_vld <= 1'b0;
         end else begin
            d_pte <= pte_i;
            d_vld <= 1'b1;
         end
      end
   end else begin : g_nodly
      assign d_pte = pte_i;
      assign d_vld = rst_n;
   end

   logic d_invalid;
   logic d_rsv;
   assign d_invalid = ~d_pte[0] | (d_pte[2] & ~d_pte[1]);
   assign d_rsv     = |d_pte[RSV_LSB +: RSV_W];

   AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n) d_vld |-> $countones({fault_o, leaf_o, next_o}) == 1); // R6
   AST_FAULT_CODE: assert property (@(posedge clk) disable iff (!rst_n) d_vld |-> (fault_o == (reason_o != 3'd0))); // R10
   AST_INVALID_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (d_vld && d_invalid) |-> (reason_o == 3'd1)); // R2
   AST_RSV_CODE: assert property (@(posedge clk) disable iff (!rst_n) (d_vld && !d_invalid && d_rsv) |-> (reason_o == 3'd2)); // R3
   AST_BASE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) d_vld |-> (next_base_o == {d_pte[PPN_LSB +: PPN_W], {PAGE_SHIFT{1'b0}}})); // R9
   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) reason_o <= 3'd6); // R10

endmodule

bind pte_validity_chk pte_validity_chk_sva #(
   .PTE_W      (PTE_W),
   .PPN_LSB    (PPN_LSB),
   .PPN_W      (PPN_W),
   .RSV_LSB    (RSV_LSB),
   .RSV_W      (RSV_W),
   .PAGE_SHIFT (PAGE_SHIFT),
   .REG_OUT    (REG_OUT),
   .SHIFT_W    (SHIFT_W),
   .PA_W       (PA_W)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .pte_i       (pte_i),
   .fault_o     (fault_o),
   .leaf_o      (leaf_o),
   .next_o      (next_o),
   .reason_o    (reason_o),
   .next_base_o (next_base_o)
);

// File: tb/pte_validity_chk_tb_top.sv
`timescale 1ns/1ps
module pte_validity_chk_tb_top;

   logic        clk;
   logic        rst_n;
   logic [63:0] pte;
   logic        mt_en;
   logic        cont_en;
   logic [5:0]  shift;
   logic        fault;
   logic        leaf;
   logic        nxt;
   logic [2:0]  reason;
   logic [55:0] base;

   int total = 0;
   int bad   = 0;

   localparam logic [7:0] V = 8'h01, R = 8'h02, W = 8'h04, X = 8'h08;
   localparam logic [7:0] U = 8'h10, G = 8'h20, A = 8'h40, D = 8'h80;

   initial clk = 1'b0;
   always #2.5 clk = ~clk;

   pte_validity_chk dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .pte_i       (pte),
      .mt_en_i     (mt_en),
      .cont_en_i   (cont_en),
      .lvl_shift_i (shift),
      .fault_o     (fault),
      .leaf_o      (leaf),
      .next_o      (nxt),
      .reason_o    (reason),
      .next_base_o (base)
   );

   function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [7:0] lo,
                                      input logic [6:0] rsv, input logic [1:0] mt,
                                      input logic cont);
      return {cont, mt, rsv, ppn, 2'b00, lo};
   endfunction

   task automatic check_out(input logic ef, input logic el, input logic en,
                            input logic [2:0] er, input string req);
      total++;
      if ({fault, leaf, nxt, reason} !== {ef, el, en, er}) begin
         bad++;
         $display("FAIL %s: got f/l/n/r=%0b%0b%0b/%0d expected %0b%0b%0b/%0d",
                  req, fault, leaf, nxt, reason, ef, el, en, er);
      end
   endtask

   task automatic check_base(input logic [55:0] eb, input string req);
      total++;
      if (base !== eb) begin
         bad++;
         $display("FAIL %s: base got %h expected %h", req, base, eb);
      end
   endtask

   // present one entry, wait for the registered result, then compare
   task automatic run(input logic [63:0] p, input logic me, input logic ce,
                      input logic [5:0] sh, input logic ef, input logic el,
                      input logic en, input logic [2:0] er, input string req);
      @(negedge clk);
      pte = p; mt_en = me; cont_en = ce; shift = sh;
      @(negedge clk);
      check_out(ef, el, en, er, req);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      pte = mk(44'h1, V | R, 7'd0, 2'd0, 1'b0);
      mt_en = 1'b0; cont_en = 1'b0; shift = 6'd0;
      repeat (3) @(negedge clk);
      check_out(1'b0, 1'b0, 1'b0, 3'd0, "R1 reset clear");
      check_base(56'h0, "R1 reset base");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_out(1'b0, 1'b1, 1'b0, 3'd0, "R1 first result after reset");
   endtask

   task automatic t_basic;
      run(mk(44'h12345, V, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 3'd0, "R6 pointer");
      check_base(56'h12345000, "R9 pointer base");
      run(mk(44'h200, V | R | X | A | D, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd9, 1'b0, 1'b1, 1'b0, 3'd0, "R6 leaf");
      check_base(56'h200000, "R9 leaf base");
      run(mk(44'h7, V | X, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd0, 1'b0, 1'b1, 1'b0, 3'd0, "R6 execute-only leaf");
   endtask

   task automatic t_invalid;
      run(mk(44'h5, R, 7'h7f, 2'd3, 1'b1), 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 3'd1, "R2 valid clear wins");
      run(mk(44'h5, V | W, 7'd0, 2'd0, 1'b0), 1'b1, 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 3'd1, "R2 write without read");
      run(mk(44'h5, V | W | X | D, 7'h1, 2'd0, 1'b0), 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 3'd1, "R2 R10 beats reserved");
   endtask

   task automatic t_reserved;
      run(mk(44'h9, V | R, 7'h01, 2'd0, 1'b0), 1'b1, 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 3'd2, "R3 low reserved bit");
      run(mk(44'h9, V | R, 7'h40, 2'd1, 1'b1), 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 3'd2, "R3 R10 beats memory type");
   endtask

   task automatic t_mtype;
      run(mk(44'h9, V | R, 7'd0, 2'd1, 1'b0), 1'b0, 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 3'd3, "R4 leaf memory type");
      run(mk(44'h9, V, 7'd0, 2'd2, 1'b0), 1'b0, 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 3'd3, "R4 pointer memory type");
      run(mk(44'h9, V | R, 7'd0, 2'd3, 1'b1), 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 3'd3, "R4 R10 beats contiguous");
      run(mk(44'h9, V | R, 7'd0, 2'd1, 1'b0), 1'b1, 1'b0, 6'd0, 1'b0, 1'b1, 1'b0, 3'd0, "R4 leaf allowed");
   endtask

   task automatic t_cont;
      run(mk(44'h10, V | R | W, 7'd0, 2'd0, 1'b1), 1'b1, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 3'd4, "R5 contiguous disabled");
      run(mk(44'h10, V | R | W, 7'd0, 2'd0, 1'b1), 1'b0, 1'b1, 6'd0, 1'b0, 1'b1, 1'b0, 3'd0, "R5 contiguous allowed");
   endtask

   task automatic t_ptr_attr;
      run(mk(44'h3, V | A, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 3'd5, "R7 accessed");
      run(mk(44'h3, V | D, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 3'd5, "R7 dirty");
      run(mk(44'h3, V | U, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 3'd5, "R7 user");
      run(mk(44'h3, V, 7'd0, 2'd1, 1'b0), 1'b1, 1'b0, 6'd0, 1'b1, 1'b0, 1'b0, 3'd5, "R7 memory type enabled");
      run(mk(44'h3, V, 7'd0, 2'd0, 1'b1), 1'b0, 1'b1, 6'd0, 1'b1, 1'b0, 1'b0, 3'd5, "R7 contiguous enabled");
   endtask

   task automatic t_align;
      run(mk(44'h201, V | R, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd9, 1'b1, 1'b0, 1'b0, 3'd6, "R8 low bit misaligned");
      run(mk(44'h200, V | R, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd10, 1'b1, 1'b0, 1'b0, 3'd6, "R8 edge bit misaligned");
      run(mk(44'h1, V | R, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd0, 1'b0, 1'b1, 1'b0, 3'd0, "R8 zero shift");
      run(mk(44'h40000, V | R, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd18, 1'b0, 1'b1, 1'b0, 3'd0, "R8 gigapage aligned");
      run(mk(44'h1, V, 7'd0, 2'd0, 1'b0), 1'b0, 1'b0, 6'd9, 1'b0, 1'b0, 1'b1, 3'd0, "R8 pointer not aligned-checked");
   endtask

   task automatic t_ignored;
      run(mk(44'h4, V | G, 7'd0, 2'd0, 1'b0) | 64'h300, 1'b0, 1'b0, 6'd0, 1'b0, 1'b0, 1'b1, 3'd0, "R11 pointer global and sw");
      check_base(56'h4000, "R11 base unaffected");
      run(mk(44'h4, V | R | G, 7'd0, 2'd0, 1'b0) | 64'h300, 1'b0, 1'b0, 6'd2, 1'b0, 1'b1, 1'b0, 3'd0, "R11 leaf global and sw");
   endtask

   initial begin
      t_reset();
      t_basic();
      t_invalid();
      t_reserved();
      t_mtype();
      t_cont();
      t_ptr_attr();
      t_align();
      t_ignored();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule